// File: doc/BRIEF.md
# Frame-Differencing Pixel Stream Processor

This block accepts digitized samples from a sensor matrix, one pixel per cycle in raster order. For each pixel it emits the difference between the new sample and the sample that the same pixel gave one frame earlier. This is correlated double sampling: it removes each pixel's fixed baseline so that a hit shows up clearly. The earlier frame is held in an on-chip store exactly one frame deep. The store is read and rewritten at the same address in the cycle that a sample is accepted, so it always holds the most recent frame.

Both the input and the output use valid/ready handshakes. Start-of-frame and end-of-frame markers travel with each sample. Each result carries the row and column of its pixel. Results of the first frame after reset are flagged as having no reference. A sensor with several matrices read in parallel uses one instance per matrix, and each instance keeps its own state. The matrix size is set by parameters: the defaults are kept small, and a 256 x 256 matrix is a parameter override.

Top module: `cds_frame_diff`

## Requirements
- R1: After synchronous reset, out_valid is 0 and in_ready is 1.
- R2: Once a reference exists, out_diff is the accepted 12-bit sample minus the sample accepted for the same pixel position in the previous frame. It is a 13-bit two's-complement value, so +4095 and -4095 are both exact.
- R3: Until the last pixel position (row ROWS-1, column COLS-1) has been accepted once after reset, every result has out_noref=1, and out_diff equals the sample zero-extended.
- R4: Every result after that first complete frame has out_noref=0.
- R5: out_col and out_row give the pixel position. Column counts fastest from 0 to COLS-1, then the row advances, and both wrap to 0 after the last pixel.
- R6: out_sof and out_eof repeat the markers of the sample that produced the result.
- R7: A sample accepted at a clock edge appears on the output right after that edge (latency of one cycle).
- R8: While out_valid=1 and out_ready=0, in_ready is 0 and every output holds its value. No sample is dropped or duplicated.
- R9: With out_ready held at 1, one sample is accepted on every cycle.
- R10: A sample marked start-of-frame is placed at row 0, column 0 even in the middle of a frame, and it is compared with the stored value for position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | 12 | Unsigned ADC sample |
| in_sof | input | 1 | Sample is the first of a frame |
| in_eof | input | 1 | Sample is the last of a frame |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_diff | output | 13 | Signed frame difference |
| out_noref | output | 1 | No previous frame was available |
| out_row | output | $clog2(ROWS) | Pixel row |
| out_col | output | $clog2(COLS) | Pixel column |
| out_sof | output | 1 | Start-of-frame marker, delayed |
| out_eof | output | 1 | End-of-frame marker, delayed |

## Verification
The bench drives the full-scale swings 0 to 4095 and 4095 to 0. A design that truncates the difference, or treats it as unsigned, gives the wrong sign or magnitude for these. It tracks the no-reference flag across the first frame boundary. A design that clears the flag one pixel too early or too late fails on exactly one pixel. A start-of-frame restart in mid-frame exposes a design that keeps counting positions or keeps reading from the old address. Random and alternating backpressure exposes a design that drops, duplicates or alters a held result.

// File: rtl/cds_pkg.sv
package cds_pkg;

    localparam int SAMPLE_W = 12;
    localparam int DIFF_W   = SAMPLE_W + 1;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [DIFF_W-1:0]   diff_t;

    typedef struct packed {
        logic sof;
        logic eof;
        logic noref;
    } tag_t;

    // current minus previous; without a reference the previous value counts as zero
    function automatic diff_t cds_sub(input sample_t cur, input sample_t prev, input logic noref);
        diff_t a;
        diff_t b;
        a = {1'b0, cur};
        b = noref ? '0 : {1'b0, prev};
        return a - b;
    endfunction

endpackage

// File: rtl/cds_raster_counter.sv
module cds_raster_counter #(
    parameter int COLS = 32,
    parameter int ROWS = 32,
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int AW    = (COLS * ROWS > 1) ? $clog2(COLS * ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             restart,
    output logic [COL_W-1:0] cur_col,
    output logic [ROW_W-1:0] cur_row,
    output logic [AW-1:0]    cur_idx,
    output logic             last
);
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    logic [AW-1:0]    idx_q;
    logic             col_end;

    assign cur_col = restart ? '0 : col_q;
    assign cur_row = restart ? '0 : row_q;
    assign cur_idx = restart ? '0 : idx_q;
    assign col_end = (cur_col == COL_W'(COLS - 1));
    assign last    = col_end && (cur_row == ROW_W'(ROWS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            row_q <= '0;
            idx_q <= '0;
        end else if (step) begin
            if (last) begin
                col_q <= '0;
                row_q <= '0;
                idx_q <= '0;
            end else begin
                idx_q <= cur_idx + AW'(1);
                if (col_end) begin
                    col_q <= '0;
                    row_q <= cur_row + ROW_W'(1);
                end else begin
                    col_q <= cur_col + COL_W'(1);
                    row_q <= cur_row;
                end
            end
        end
    end
endmodule

// File: rtl/cds_frame_store.sv
module cds_frame_store #(
    parameter int DEPTH = 1024,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [AW-1:0]            addr,
    input  cds_pkg::sample_t         wr_data,
    output cds_pkg::sample_t         rd_data
);
    cds_pkg::sample_t mem [DEPTH];

    // read returns the value from one frame ago; write replaces it at the same edge
    assign rd_data = mem[addr];

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wr_data;
    end
endmodule

// File: rtl/cds_out_stage.sv
module cds_out_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] d,
    output logic         take,
    output logic         valid,
    input  logic         ready,
    output logic [W-1:0] q
);
    assign take = !valid || ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
        end else if (take) begin
            valid <= push;
        end
    end

    always_ff @(posedge clk) begin
        if (push && take) q <= d;
    end
endmodule

// File: rtl/cds_frame_diff.sv
module cds_frame_diff #(
    parameter int COLS = 32,
    parameter int ROWS = 32,
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int DEPTH = COLS * ROWS,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [cds_pkg::SAMPLE_W-1:0] in_data,
    input  logic                       in_sof,
    input  logic                       in_eof,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [cds_pkg::DIFF_W-1:0] out_diff,
    output logic                       out_noref,
    output logic [ROW_W-1:0]           out_row,
    output logic [COL_W-1:0]           out_col,
    output logic                       out_sof,
    output logic                       out_eof
);
    import cds_pkg::*;

    typedef struct packed {
        diff_t            diff;
        tag_t             tag;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } result_t;

    logic             accept;
    logic             last_pix;
    logic             have_ref;
    logic [COL_W-1:0] cur_col;
    logic [ROW_W-1:0] cur_row;
    logic [AW-1:0]    cur_idx;
    sample_t          prev_sample;
    result_t          res_d;
    result_t          res_q;

    assign accept = in_valid && in_ready;

    cds_raster_counter #(.COLS(COLS), .ROWS(ROWS)) u_pos (
        .clk     (clk),
        .rst     (rst),
        .step    (accept),
        .restart (in_sof),
        .cur_col (cur_col),
        .cur_row (cur_row),
        .cur_idx (cur_idx),
        .last    (last_pix)
    );

    cds_frame_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (accept),
        .addr    (cur_idx),
        .wr_data (in_data),
        .rd_data (prev_sample)
    );

    // reference becomes available once the final position of a frame was written
    always_ff @(posedge clk) begin
        if (rst)                     have_ref <= 1'b0;
        else if (accept && last_pix) have_ref <= 1'b1;
    end

    always_comb begin
        res_d.diff      = cds_sub(in_data, prev_sample, !have_ref);
        res_d.tag.sof   = in_sof;
        res_d.tag.eof   = in_eof;
        res_d.tag.noref = !have_ref;
        res_d.row       = cur_row;
        res_d.col       = cur_col;
    end

    cds_out_stage #(.W($bits(result_t))) u_out (
        .clk   (clk),
        .rst   (rst),
        .push  (in_valid),
        .d     (res_d),
        .take  (in_ready),
        .valid (out_valid),
        .ready (out_ready),
        .q     (res_q)
    );

    assign out_diff  = res_q.diff;
    assign out_noref = res_q.tag.noref;
    assign out_sof   = res_q.tag.sof;
    assign out_eof   = res_q.tag.eof;
    assign out_row   = res_q.row;
    assign out_col   = res_q.col;
endmodule

// File: rtl/cds_frame_diff_checker.sv
module cds_frame_diff_checker #(
    parameter int COLS = 32,
    parameter int ROWS = 32,
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic [cds_pkg::DIFF_W-1:0] out_diff,
    input logic                       out_noref,
    input logic [ROW_W-1:0]           out_row,
    input logic [COL_W-1:0]           out_col,
    input logic                       out_sof
);
    assert_stall_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_diff) && $stable(out_row)
                                       && $stable(out_col) && $stable(out_noref)));

    assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    assert_sof_origin_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sof) |-> (out_row == '0 && out_col == '0));

    assert_index_range_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (32'(out_col) < COLS && 32'(out_row) < ROWS));

    assert_noref_positive_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_noref) |-> !out_diff[cds_pkg::DIFF_W-1]);

    assert_ref_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_noref) |=> !(out_valid && out_noref));
endmodule

bind cds_frame_diff cds_frame_diff_checker #(.COLS(COLS), .ROWS(ROWS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_diff  (out_diff),
    .out_noref (out_noref),
    .out_row   (out_row),
    .out_col   (out_col),
    .out_sof   (out_sof)
);

// File: tb/test_cds_frame_diff.sv
`timescale 1ns/1ps
module test_cds_frame_diff;
    localparam int COLS = 4;
    localparam int ROWS = 3;
    localparam int NPIX = COLS * ROWS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] in_data = '0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [12:0] out_diff;
    logic        out_noref;
    logic [1:0]  out_row;
    logic [1:0]  out_col;
    logic        out_sof;
    logic        out_eof;

    always #10 clk = ~clk;

    cds_frame_diff #(.COLS(COLS), .ROWS(ROWS)) i_cds_frame_diff (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .out_valid(out_valid), .out_ready(out_ready), .out_diff(out_diff),
        .out_noref(out_noref), .out_row(out_row), .out_col(out_col),
        .out_sof(out_sof), .out_eof(out_eof)
    );

    typedef struct {
        int diff;
        bit noref;
        int row;
        int col;
        bit sof;
        bit eof;
    } exp_t;

    exp_t expq[$];
    int   checks = 0;
    int   fails = 0;
    int   ref_mem[NPIX];
    bit   ref_ok = 0;
    int   idx = 0;
    int   ready_mode = 0;
    int   cyc = 0;
    bit   done = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // downstream ready pattern, changed just after each edge
    always @(posedge clk) begin
        #1;
        case (ready_mode)
            0: out_ready = 1'b1;
            1: out_ready = ~out_ready;
            default: out_ready = (($urandom % 3) != 0);
        endcase
    end

    // driver: builds the expected result, then offers the sample until accepted
    task automatic send(input int data, input bit sof, input bit eof);
        exp_t e;
        if (sof) idx = 0;
        e.noref = !ref_ok;
        e.diff  = ref_ok ? data - ref_mem[idx] : data;
        e.row   = idx / COLS;
        e.col   = idx % COLS;
        e.sof   = sof;
        e.eof   = eof;
        ref_mem[idx] = data;
        if (idx == NPIX - 1) ref_ok = 1;
        idx = (idx + 1) % NPIX;
        expq.push_back(e);
        in_valid = 1'b1;
        in_data  = data[11:0];
        in_sof   = sof;
        in_eof   = eof;
        forever begin
            #1;
            if (in_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        chk(out_valid === 1'b1, "R7", "out_valid after accept", int'(out_valid), 1);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
    endtask

    // monitor: scoreboard compare on each transfer, hold check on each stall
    bit   stalled = 0;
    int   held_diff = 0;
    int   held_col = 0;
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            if (stalled) begin
                chk(out_valid === 1'b1, "R8", "valid held", int'(out_valid), 1);
                chk(int'($signed(out_diff)) == held_diff, "R8", "diff held", int'($signed(out_diff)), held_diff);
                chk(int'(out_col) == held_col, "R8", "col held", int'(out_col), held_col);
            end
            stalled = out_valid && !out_ready;
            if (stalled) begin
                held_diff = int'($signed(out_diff));
                held_col  = int'(out_col);
                chk(in_ready === 1'b0, "R8", "in_ready while stalled", int'(in_ready), 0);
            end
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    chk(0, "R8", "unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(int'($signed(out_diff)) == e.diff, e.noref ? "R3" : "R2", "diff",
                        int'($signed(out_diff)), e.diff);
                    chk(out_noref == e.noref, e.noref ? "R3" : "R4", "noref", int'(out_noref), int'(e.noref));
                    chk(int'(out_row) == e.row, "R5", "row", int'(out_row), e.row);
                    chk(int'(out_col) == e.col, "R5", "col", int'(out_col), e.col);
                    chk(out_sof == e.sof, "R6", "sof", int'(out_sof), int'(e.sof));
                    chk(out_eof == e.eof, "R6", "eof", int'(out_eof), int'(e.eof));
                end
            end
        end
    end

    initial begin
        #2000000;
        chk(0, "ALL", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int t0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(out_valid === 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(in_ready === 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

        // first frame: no reference yet (R3)
        for (int i = 0; i < NPIX; i++) send(100 + 7 * i, i == 0, i == NPIX - 1);

        // second frame back to back with full-scale values; throughput (R9)
        t0 = cyc;
        for (int i = 0; i < NPIX; i++)
            send(i == 0 ? 4095 : (i == 1 ? 0 : 200 + i), i == 0, i == NPIX - 1);
        chk(cyc - t0 == NPIX, "R9", "cycles per frame", cyc - t0, NPIX);

        // third frame with alternating backpressure, signed extremes (R2, R8)
        ready_mode = 1;
        for (int i = 0; i < NPIX; i++)
            send(i == 0 ? 0 : (i == 1 ? 4095 : 180 + 3 * i), i == 0, i == NPIX - 1);

        // partial frame, then a restart marked start-of-frame (R10)
        ready_mode = 2;
        for (int i = 0; i < 5; i++) send(int'($urandom % 4096), i == 0, 1'b0);
        for (int i = 0; i < NPIX; i++) send(int'($urandom % 4096), i == 0, i == NPIX - 1);
        for (int i = 0; i < NPIX; i++) send(int'($urandom % 4096), i == 0, i == NPIX - 1);

        ready_mode = 0;
        repeat (6) @(negedge clk);
        chk(expq.size() == 0, "R8", "results outstanding", expq.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule